// File: doc/BRIEF.md
# Four-Mode Serial Port Controller

This block is a serial port with one shared engine set and four selectable modes. Mode 0 is a half-duplex synchronous shifter. The data pin carries eight bits in one direction at a time. The clock pin drives a shift clock at one twelfth of the core clock. Modes 1, 2 and 3 are full-duplex asynchronous modes. Mode 1 sends a 10-bit frame. Modes 2 and 3 send an 11-bit frame that carries a ninth data bit. On transmit that bit comes from an input. On receive it is captured into a status output. Software may use it as parity or as a command/data marker.

The bit rate of mode 2 is a fixed fraction of the core clock. Modes 1 and 3 take their rate from an external timer overflow tick. A rate-doubling input halves the divider in modes 1, 2 and 3. One data buffer serves both directions. A write starts a transmission. The read data output always shows the last accepted received byte. Two sticky done flags drive one interrupt output, and each flag is cleared by its own pulse. The pad logic outside the block combines the data pin output, its enable and its input into one bidirectional pad.

Top module: `sp_ctrl`

## Requirements
- R1: After reset, the clock/TxD pin is 1 and the data pin enable is 0. Both done flags, the interrupt, the ninth received bit and the read data are 0.
- R2: In mode 0 (mode_i = 0), a buffer write shifts 8 bits out on the data pin, LSB first, with the data pin enable at 1. Each bit lasts 12 clocks. The clock pin is low for the first 6 clocks of each bit and high for the last 6. The clock pin is 1 when idle. The transmit-done flag sets after the eighth bit. A data bit does not change while its bit period lasts.
- R3: In mode 0, a reception starts when receive enable is 1, the receive-done flag is 0 and the engine is idle. The data pin input is sampled at each rising edge of the clock pin, LSB first, with the pin enable at 0. After 8 bits the byte is loaded into the read data and the receive-done flag sets.
- R4: In mode 0, no reception starts while the receive-done flag is set. The clock pin stays at 1.
- R5: An asynchronous transmit frame starts with a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. In modes 2 and 3 (mode_i = 2 or 3) the transmit ninth bit sits between the data and the stop bit, giving 11 bits. Mode 1 (mode_i = 1) sends 10 bits and ignores that input. The transmit-done flag sets at the end of the stop bit.
- R6: In mode 2 one bit lasts 64 clocks, or 32 clocks with rate doubling set.
- R7: In modes 1 and 3 one bit lasts 32 timer ticks, or 16 timer ticks with rate doubling set.
- R8: With receive enable at 1, an asynchronous reception starts on a falling edge of the RxD input. Each bit is sampled at its centre. When the stop bit is 1, the byte is loaded and the receive-done flag sets. The ninth received bit takes the frame's ninth bit in modes 2 and 3, and the stop bit in mode 1.
- R9: A frame whose stop bit samples as 0 is dropped: the receive-done flag stays 0, and the read data and ninth bit keep their values.
- R10: An asynchronous frame that completes while the receive-done flag is still set is dropped, and the read data keeps its value.
- R11: Both done flags stay set until their clear pulse. The interrupt output is 1 while either flag is set.
- R12: With receive enable at 0, an asynchronous frame on RxD is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode select 0..3 |
| smod_i | input | 1 | Rate doubling for modes 1, 2, 3 |
| ren_i | input | 1 | Receive enable |
| tb8_i | input | 1 | Ninth transmit bit (modes 2, 3) |
| tick_i | input | 1 | External timer overflow tick, one clock wide |
| wr_i | input | 1 | Data buffer write strobe, starts a transmission |
| wdata_i | input | 8 | Data buffer write value |
| clr_ti_i | input | 1 | Clear pulse for the transmit-done flag |
| clr_ri_i | input | 1 | Clear pulse for the receive-done flag |
| rxd_i | input | 1 | Data/RxD pin input |
| rdata_o | output | 8 | Last accepted received byte |
| rb8_o | output | 1 | Ninth received bit |
| ti_o | output | 1 | Transmit-done flag |
| ri_o | output | 1 | Receive-done flag |
| irq_o | output | 1 | Interrupt, OR of the flags |
| txd_o | output | 1 | Shift clock in mode 0, TxD otherwise |
| rxd_o | output | 1 | Data pin output value in mode 0 |
| rxd_oe_o | output | 1 | Data pin output enable |

## Verification
In mode 0 the clock pin falls on the first edge after the write or enable, and the transmit-done flag follows the eighth rising edge within 7 clocks. The bench therefore follows the clock pin's own edges: it drives receive data after each falling edge and samples transmit data just after each rising edge. Asynchronous results depend on the free-running prescaler phase, so the bench times each frame from the observed start edge. It samples every bit at its centre, checks the frame length against the nominal bit count within one oversample tick plus register latency, and reads flags and read data one full bit period after the stop bit. Flag clears and the blocked-start cases are checked on the next falling clock edge, or over a fixed watch window.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC  = 2'd0,
    MODE_A10   = 2'd1,
    MODE_A11_F = 2'd2,
    MODE_A11_T = 2'd3
  } sp_mode_e;
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int OVS     = 16,
  parameter int OSC_DIV = 64,
  parameter int TMR_DIV = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       smod_i,
  input  logic       tick_i,
  output logic       stick_o
);
  localparam int OSC_PRE = OSC_DIV / OVS;
  localparam int TMR_PRE = TMR_DIV / OVS;
  localparam int MAXP    = (OSC_PRE > TMR_PRE) ? OSC_PRE : TMR_PRE;
  localparam int CW      = $clog2(MAXP) + 1;

  logic [CW-1:0] cnt_q, lim;
  logic          inc;

  always_comb begin
    if (mode_i == 2'd2) begin
      inc = 1'b1;
      lim = smod_i ? CW'(OSC_PRE / 2) : CW'(OSC_PRE);
    end else begin
      inc = tick_i;
      lim = smod_i ? CW'(TMR_PRE / 2) : CW'(TMR_PRE);
    end
  end

  assign stick_o = inc && (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else if (inc) cnt_q <= stick_o ? '0 : cnt_q + 1'b1;

  // R6: oversample ticks in mode 2 are never back to back without doubling
  p_osc_rate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stick_o && mode_i == 2'd2 && !smod_i) |=> (!stick_o || mode_i != 2'd2));
endmodule

// File: rtl/sp_sync_eng.sv
module sp_sync_eng #(
  parameter int DW  = 8,
  parameter int DIV = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  input  logic          ri_i,
  input  logic          rxd_i,
  output logic          sclk_o,
  output logic          dout_o,
  output logic          oe_o,
  output logic          tx_done_o,
  output logic          rx_done_o,
  output logic [DW-1:0] rx_data_o
);
  localparam int HALF = DIV / 2;
  localparam int PW   = $clog2(DIV);
  localparam int BW   = $clog2(DW);

  logic          busy_q, dir_tx_q;
  logic [PW-1:0] phase_q;
  logic [BW-1:0] bitc_q;
  logic [DW-1:0] sh_q;
  logic          start_tx, start_rx;

  assign start_tx = en_i && wr_i;
  // rx_done_o blocks a restart in the cycle before the flag is visible
  assign start_rx = en_i && ren_i && !ri_i && !rx_done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      dir_tx_q  <= 1'b0;
      phase_q   <= '0;
      bitc_q    <= '0;
      sh_q      <= '0;
      tx_done_o <= 1'b0;
      rx_done_o <= 1'b0;
    end else begin
      tx_done_o <= 1'b0;
      rx_done_o <= 1'b0;
      if (!busy_q) begin
        if (start_tx) begin
          busy_q   <= 1'b1;
          dir_tx_q <= 1'b1;
          sh_q     <= wdata_i;
          phase_q  <= '0;
          bitc_q   <= '0;
        end else if (start_rx) begin
          busy_q   <= 1'b1;
          dir_tx_q <= 1'b0;
          phase_q  <= '0;
          bitc_q   <= '0;
        end
      end else begin
        if (!dir_tx_q && phase_q == PW'(HALF)) sh_q <= {rxd_i, sh_q[DW-1:1]};
        if (phase_q == PW'(DIV-1)) begin
          phase_q <= '0;
          if (dir_tx_q) sh_q <= {1'b0, sh_q[DW-1:1]};
          if (bitc_q == BW'(DW-1)) begin
            busy_q    <= 1'b0;
            tx_done_o <= dir_tx_q;
            rx_done_o <= !dir_tx_q;
          end else begin
            bitc_q <= bitc_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o    = busy_q ? (phase_q >= PW'(HALF)) : 1'b1;
  assign dout_o    = sh_q[0];
  assign oe_o      = busy_q && dir_tx_q;
  assign rx_data_o = sh_q;

  p_ri_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && ri_i && !start_tx) |=> !busy_q);

  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dir_tx_q && phase_q != PW'(DIV-1)) |=> $stable(dout_o));
endmodule

// File: rtl/sp_async_tx.sv
module sp_async_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          nine_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tb8_i,
  input  logic          stick_i,
  output logic          txd_o,
  output logic          done_o
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW);
  localparam int TW = $clog2(OVS);

  logic          busy_q, nine_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] bitc_q, last;
  logic [TW-1:0] tcnt_q;

  assign last = nine_q ? CW'(FW-1) : CW'(FW-2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      nine_q <= 1'b0;
      sh_q   <= '1;
      bitc_q <= '0;
      tcnt_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (en_i && wr_i) begin
          busy_q <= 1'b1;
          nine_q <= nine_i;
          sh_q   <= nine_i ? {1'b1, tb8_i, wdata_i, 1'b0} : {2'b11, wdata_i, 1'b0};
          bitc_q <= '0;
          tcnt_q <= '0;
        end
      end else if (stick_i) begin
        if (tcnt_q == TW'(OVS-1)) begin
          tcnt_q <= '0;
          sh_q   <= {1'b1, sh_q[FW-1:1]};
          if (bitc_q == last) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bitc_q <= bitc_q + 1'b1;
          end
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  assign txd_o = busy_q ? sh_q[0] : 1'b1;

  p_start_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !txd_o);
endmodule

// File: rtl/sp_async_rx.sv
module sp_async_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          nine_i,
  input  logic          ren_i,
  input  logic          rxd_i,
  input  logic          stick_i,
  output logic          ok_o,
  output logic          bad_o,
  output logic [DW-1:0] data_o,
  output logic          b9_o
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW);
  localparam int TW = $clog2(OVS);

  logic          s1_q, s2_q, s3_q, busy_q, nine_q, fall;
  logic [DW:0]   sh_q;
  logic [CW-1:0] bitc_q, last;
  logic [TW-1:0] tcnt_q;

  assign fall = s3_q && !s2_q;
  assign last = nine_q ? CW'(FW-1) : CW'(FW-2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      busy_q <= 1'b0;
      nine_q <= 1'b0;
      sh_q   <= '0;
      bitc_q <= '0;
      tcnt_q <= '0;
      ok_o   <= 1'b0;
      bad_o  <= 1'b0;
    end else begin
      s1_q  <= rxd_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      ok_o  <= 1'b0;
      bad_o <= 1'b0;
      if (!busy_q) begin
        if (en_i && ren_i && fall) begin
          busy_q <= 1'b1;
          nine_q <= nine_i;
          bitc_q <= '0;
          tcnt_q <= '0;
        end
      end else if (stick_i) begin
        tcnt_q <= tcnt_q + 1'b1;
        if (tcnt_q == TW'(OVS-1)) bitc_q <= bitc_q + 1'b1;
        if (tcnt_q == TW'(OVS/2-1)) begin
          if (bitc_q == '0) begin
            if (s2_q) busy_q <= 1'b0;  // glitch, not a start bit
          end else if (bitc_q == last) begin
            busy_q <= 1'b0;
            ok_o   <= s2_q;
            bad_o  <= !s2_q;
          end else begin
            sh_q <= {s2_q, sh_q[DW:1]};
          end
        end
      end
    end
  end

  assign data_o = nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
  assign b9_o   = nine_q ? sh_q[DW] : 1'b1;
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int SYNC_DIV = 12,
  parameter int OSC_DIV  = 64,
  parameter int TMR_DIV  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              smod_i,
  input  logic              ren_i,
  input  logic              tb8_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_ti_i,
  input  logic              clr_ri_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rb8_o,
  output logic              ti_o,
  output logic              ri_o,
  output logic              irq_o,
  output logic              txd_o,
  output logic              rxd_o,
  output logic              rxd_oe_o
);
  import sp_pkg::*;

  sp_mode_e          mode;
  logic              m_sync, nine, stick;
  logic              s_sclk, s_dout, s_oe, s_tx_done, s_rx_done;
  logic [DATA_W-1:0] s_rx_data, a_rx_data;
  logic              a_txd, a_tx_done, a_ok, a_bad, a_b9;
  logic              ti_q, ri_q, rb8_q, a_take;
  logic [DATA_W-1:0] rbuf_q;

  assign mode   = sp_mode_e'(mode_i);
  assign m_sync = (mode == MODE_SYNC);
  assign nine   = (mode == MODE_A11_F) || (mode == MODE_A11_T);

  sp_baud #(.OVS(OVS), .OSC_DIV(OSC_DIV), .TMR_DIV(TMR_DIV)) u_baud (
    .clk_i, .rst_ni, .mode_i, .smod_i, .tick_i, .stick_o(stick)
  );

  sp_sync_eng #(.DW(DATA_W), .DIV(SYNC_DIV)) u_sync (
    .clk_i, .rst_ni, .en_i(m_sync), .wr_i, .wdata_i, .ren_i, .ri_i(ri_q),
    .rxd_i, .sclk_o(s_sclk), .dout_o(s_dout), .oe_o(s_oe),
    .tx_done_o(s_tx_done), .rx_done_o(s_rx_done), .rx_data_o(s_rx_data)
  );

  sp_async_tx #(.DW(DATA_W), .OVS(OVS)) u_atx (
    .clk_i, .rst_ni, .en_i(!m_sync), .nine_i(nine), .wr_i, .wdata_i, .tb8_i,
    .stick_i(stick), .txd_o(a_txd), .done_o(a_tx_done)
  );

  sp_async_rx #(.DW(DATA_W), .OVS(OVS)) u_arx (
    .clk_i, .rst_ni, .en_i(!m_sync), .nine_i(nine), .ren_i, .rxd_i,
    .stick_i(stick), .ok_o(a_ok), .bad_o(a_bad), .data_o(a_rx_data), .b9_o(a_b9)
  );

  assign a_take = a_ok && !ri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rb8_q  <= 1'b0;
      rbuf_q <= '0;
    end else begin
      if (s_tx_done || a_tx_done) ti_q <= 1'b1;
      else if (clr_ti_i)          ti_q <= 1'b0;
      if (s_rx_done || a_take)    ri_q <= 1'b1;
      else if (clr_ri_i)          ri_q <= 1'b0;
      if (s_rx_done) rbuf_q <= s_rx_data;
      else if (a_take) begin
        rbuf_q <= a_rx_data;
        rb8_q  <= a_b9;
      end
    end
  end

  assign txd_o    = m_sync ? s_sclk : a_txd;
  assign rxd_o    = s_dout;
  assign rxd_oe_o = m_sync && s_oe;
  assign rdata_o  = rbuf_q;
  assign rb8_o    = rb8_q;
  assign ti_o     = ti_q;
  assign ri_o     = ri_q;
  assign irq_o    = ti_q || ri_q;

  p_bad_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_bad && !ri_q) |=> !ri_q);

  p_buf_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ok && ri_q) |=> $stable(rbuf_q));

  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ti_q && !clr_ti_i) |=> ti_q);
endmodule

// File: tb/sp_ctrl_tb.sv
`timescale 1ns/1ps
module sp_ctrl_tb;
  localparam int TICK_P = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = 2'd1;
  logic       smod_i = 1'b0, ren_i = 1'b0, tb8_i = 1'b0, tick_i = 1'b0;
  logic       wr_i = 1'b0, clr_ti_i = 1'b0, clr_ri_i = 1'b0, rxd_i = 1'b1;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       rb8_o, ti_o, ri_o, irq_o, txd_o, rxd_o, rxd_oe_o;

  int checks = 0, failures = 0;
  int nb, pb;
  logic [7:0] exp_buf;
  logic       exp_rb8;

  // {mode, smod, tb8, data}
  localparam logic [11:0] TXV [6] = '{
    {2'd1, 1'b0, 1'b0, 8'hA5}, {2'd1, 1'b1, 1'b1, 8'h3C},
    {2'd2, 1'b0, 1'b1, 8'h81}, {2'd2, 1'b1, 1'b0, 8'hFE},
    {2'd3, 1'b0, 1'b1, 8'h00}, {2'd3, 1'b1, 1'b0, 8'h5A}};
  // {mode, smod, ninth, stop, data}
  localparam logic [12:0] RXV [6] = '{
    {2'd1, 1'b0, 1'b0, 1'b1, 8'hC3}, {2'd2, 1'b1, 1'b1, 1'b1, 8'h96},
    {2'd3, 1'b0, 1'b0, 1'b1, 8'h7E}, {2'd3, 1'b1, 1'b1, 1'b0, 8'h11},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h01}, {2'd1, 1'b1, 1'b1, 1'b1, 8'hF0}};

  sp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i, .smod_i, .ren_i, .tb8_i, .tick_i,
    .wr_i, .wdata_i, .clr_ti_i, .clr_ri_i, .rxd_i, .rdata_o, .rb8_o, .ti_o,
    .ri_o, .irq_o, .txd_o, .rxd_o, .rxd_oe_o
  );

  always #2.5 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick_i = (c == TICK_P - 1);
      c = (c == TICK_P - 1) ? 0 : c + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clk(input logic [1:0] m, input logic s);
    if (m == 2'd2) return s ? 32 : 64;
    return TICK_P * (s ? 16 : 32);
  endfunction

  task automatic pulse_clr(input logic t, input logic r);
    @(negedge clk); clr_ti_i = t; clr_ri_i = r;
    @(negedge clk); clr_ti_i = 1'b0; clr_ri_i = 1'b0;
  endtask

  task automatic wait_flag(input logic which, input int lim, output int n);
    n = 0;
    while (((which ? ri_o : ti_o) !== 1'b1) && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic rx_drive(input int nbits, input logic [10:0] bits, input int per);
    for (int k = 0; k < nbits; k++) begin
      rxd_i = bits[k];
      repeat (per) @(negedge clk);
    end
    rxd_i = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  initial begin
    logic [10:0] got, ef;
    logic [7:0]  d;
    int n, el;
    realtime tf0, tf1, tr0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", txd_o, 1);
    chk("R1 oe", rxd_oe_o, 0);
    chk("R1 flags", {ti_o, ri_o, irq_o, rb8_o}, 0);
    chk("R1 rdata", rdata_o, 0);

    // R2 mode 0 transmit
    mode_i = 2'd0; wdata_i = 8'hB4; wr_i = 1'b1;
    fork begin @(negedge clk); wr_i = 1'b0; end join_none
    got = '0; tf0 = 0; tf1 = 0; tr0 = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge txd_o);
      if (k == 0) tf0 = $realtime;
      if (k == 1) tf1 = $realtime;
      @(posedge txd_o);
      if (k == 0) tr0 = $realtime;
      #1;
      got[k] = rxd_o;
      chk("R2 oe during tx", rxd_oe_o, 1);
    end
    chk("R2 shifted byte", got[7:0], 8'hB4);
    chk("R2 clock low 6 cycles", int'((tr0 - tf0) * 10.0), 300);
    chk("R2 bit period 12 cycles", int'((tf1 - tf0) * 10.0), 600);
    chk("R2 ti before end", ti_o, 0);
    wait_flag(1'b0, 20, n);
    chk("R2 ti set", ti_o, 1);
    chk("R2 clock idle high", txd_o, 1);

    // R11 sticky flag and interrupt
    repeat (50) @(negedge clk);
    chk("R11 ti sticky", ti_o, 1);
    chk("R11 irq follows ti", irq_o, 1);
    pulse_clr(1'b1, 1'b0);
    chk("R11 ti cleared", ti_o, 0);
    chk("R11 irq cleared", irq_o, 0);

    // R3 mode 0 receive
    d = 8'h69;
    @(negedge clk); ren_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge txd_o);
      #1;
      rxd_i = d[k];
      chk("R3 oe low during rx", rxd_oe_o, 0);
    end
    wait_flag(1'b1, 30, n);
    ren_i = 1'b0; rxd_i = 1'b1;
    chk("R3 ri set", ri_o, 1);
    chk("R3 rdata", rdata_o, 8'h69);
    exp_buf = 8'h69; exp_rb8 = 1'b0;

    // R4 no start while ri set
    ren_i = 1'b1; n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (txd_o !== 1'b1) n++; end
    chk("R4 no clock while ri set", n, 0);
    ren_i = 1'b0;
    pulse_clr(1'b0, 1'b1);
    chk("R11 ri cleared", ri_o, 0);

    // R5 R6 R7 asynchronous transmit table
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mode_i = TXV[i][11:10]; smod_i = TXV[i][9]; tb8_i = TXV[i][8]; d = TXV[i][7:0];
      nb = (mode_i == 2'd1) ? 10 : 11;
      pb = bit_clk(mode_i, smod_i);
      ef = (nb == 10) ? {2'b01, d, 1'b0} : {1'b1, tb8_i, d, 1'b0};
      pulse_clr(1'b1, 1'b0);
      @(negedge clk); wdata_i = d; wr_i = 1'b1;
      @(negedge clk); wr_i = 1'b0;
      n = 0;
      while (txd_o !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
      got = '0; el = 0;
      repeat (pb / 2) begin @(negedge clk); el++; end
      for (int k = 0; k < nb; k++) begin
        got[k] = txd_o;
        if (k < nb - 1) repeat (pb) begin @(negedge clk); el++; end
      end
      chk($sformatf("R5 frame mode%0d", mode_i), got, ef);
      chk("R5 ti clear mid stop", ti_o, 0);
      wait_flag(1'b0, pb, n);
      el = el + n;
      chk("R5 ti set after stop", ti_o, 1);
      chk($sformatf("%s frame length mode%0d smod%0d", (mode_i == 2'd2) ? "R6" : "R7",
          mode_i, smod_i),
          ((el >= nb * pb - pb / 16 - 4) && (el <= nb * pb + 4)) ? 1 : 0, 1);
    end

    // R8 R9 asynchronous receive table
    pulse_clr(1'b1, 1'b1);
    ren_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mode_i = RXV[i][12:11]; smod_i = RXV[i][10]; d = RXV[i][7:0];
      nb = (mode_i == 2'd1) ? 10 : 11;
      pb = bit_clk(mode_i, smod_i);
      ef = (nb == 10) ? {1'b0, RXV[i][8], d, 1'b0} : {RXV[i][8], RXV[i][9], d, 1'b0};
      pulse_clr(1'b0, 1'b1);
      repeat (4) @(negedge clk);
      rx_drive(nb, ef, pb);
      if (RXV[i][8]) begin
        exp_buf = d;
        exp_rb8 = (mode_i == 2'd1) ? 1'b1 : RXV[i][9];
        chk("R8 ri set", ri_o, 1);
        chk("R8 rdata", rdata_o, exp_buf);
        chk("R8 rb8", rb8_o, exp_rb8);
      end else begin
        chk("R9 ri stays clear", ri_o, 0);
        chk("R9 rdata kept", rdata_o, exp_buf);
        chk("R9 rb8 kept", rb8_o, exp_rb8);
      end
    end

    // R10 frame completing while ri set is dropped (mode 1, smod 1)
    chk("R10 ri still set", ri_o, 1);
    rx_drive(10, {2'b01, 8'h0F, 1'b0}, pb);
    chk("R10 rdata kept", rdata_o, exp_buf);
    chk("R10 ri kept", ri_o, 1);

    // R12 receive disabled
    pulse_clr(1'b0, 1'b1);
    ren_i = 1'b0;
    rx_drive(10, {2'b01, 8'h33, 1'b0}, pb);
    chk("R12 ri stays clear", ri_o, 0);
    chk("R12 rdata kept", rdata_o, exp_buf);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule